// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic and logic stage of a small 8-bit datapath. Each transfer brings in the current accumulator, a second operand and the current flag byte. A selector picks either one of eight two-operand operations or a one-operand increment or decrement. The block registers the new accumulator value and the new flag byte on the clock edge where the strobe is high. One cycle later it raises its own valid output.

The flag byte has a fixed layout so that neighbouring logic can decode it: bit 7 is zero (Z), bit 6 is subtract (N), bit 5 is half-carry (H) and bit 4 is carry (C). Bits 3..0 are always zero. Each operation has its own flag rule. Logic operations discard the carry, and AND raises the half-carry. Compare changes only the flags. Increment and decrement keep the incoming carry.

Top module: `accflag_alu`

## Requirements
- R1: While reset is low, and in the cycle after it, `out_valid`, `acc_out` and `flags_out` are all zero.
- R2: With `unary_sel`=00 the `op_sel` codes map as follows: 000 add, 001 add-with-carry, 010 subtract, 011 subtract-with-borrow, 100 AND, 101 XOR, 110 OR, 111 compare. The carry-in for 001 and 011 is `flags_in` bit 4. The arithmetic result is taken modulo 256.
- R3: Add and add-with-carry clear N. They set H when the low-nibble sum plus the carry-in exceeds 0xF. They set C when the full sum exceeds 0xFF.
- R4: Subtract and subtract-with-borrow set N. They set H when the operand's low nibble plus the borrow-in exceeds the accumulator's low nibble. They set C when the operand plus the borrow-in exceeds the accumulator.
- R5: Compare produces the subtract flags, and `acc_out` equals `acc_in` unchanged.
- R6: AND sets H and clears N and C. XOR and OR clear N, H and C.
- R7: Z (bit 7) is set exactly when the 8-bit result is zero. For compare, the result is the difference.
- R8: `unary_sel`=01 gives `opnd_in`+1. It clears N, sets H when the result's low nibble is 0, and copies C from `flags_in` bit 4.
- R9: `unary_sel`=10 gives `opnd_in`-1. It sets N, sets H when the result's low nibble is 0xF, and copies C from `flags_in` bit 4.
- R10: `unary_sel`=11 passes `acc_in` through, and passes `flags_in` through with its low nibble cleared.
- R11: Bits 3..0 of `flags_out` are zero in every case, whatever `flags_in` holds.
- R12: The outputs load only on an edge where `in_valid` is high and otherwise hold. `out_valid` equals `in_valid` as it was one edge earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe that loads a new result |
| unary_sel | input | 2 | 00 two-operand, 01 increment, 10 decrement, 11 pass |
| op_sel | input | 3 | Two-operand operation code |
| acc_in | input | 8 | Current accumulator |
| opnd_in | input | 8 | Second operand, or the increment/decrement source |
| flags_in | input | 8 | Current flag byte |
| out_valid | output | 1 | Strobe echoed one cycle later |
| acc_out | output | 8 | Registered result |
| flags_out | output | 8 | Registered flag byte |

## Verification
Every operation code is driven with operand pairs chosen to separate nibble carries from full carries. These include a sum that wraps to zero with both carries, a nibble carry without a full carry, and a plain sum with neither. Subtract and subtract-with-borrow run with the borrow-in both set and clear, including an operand plus borrow that equals the accumulator exactly, which must raise H but not C. Logic operations run with all flags set on input, so that stale carries and half-carries show up. Increment and decrement run across the 0x0F/0x10 and 0xFF/0x00 boundaries with the incoming carry at both values. A final set of tests drops the strobe while the inputs change, which tells holding apart from free-running loads.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int FLAG_W = 8;
    localparam int FZ_BIT = 7;
    localparam int FN_BIT = 6;
    localparam int FH_BIT = 5;
    localparam int FC_BIT = 4;
    localparam logic [FLAG_W-1:0] FLAG_MASK = 8'hF0;

    typedef enum logic [2:0] {
        OP_ADD = 3'b000,
        OP_ADC = 3'b001,
        OP_SUB = 3'b010,
        OP_SBC = 3'b011,
        OP_AND = 3'b100,
        OP_XOR = 3'b101,
        OP_OR  = 3'b110,
        OP_CMP = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        UN_BIN  = 2'b00,
        UN_INC  = 2'b01,
        UN_DEC  = 2'b10,
        UN_PASS = 2'b11
    } unary_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flag_t;

    function automatic logic [FLAG_W-1:0] pack_flags(input flag_t f);
        return {f.z, f.n, f.h, f.c, 4'b0000};
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] res_o,
    output logic              half_o,
    output logic              carry_o
);
    localparam int NIB_W = DATA_W / 2;

    logic [NIB_W:0]  lo_d;
    logic [DATA_W:0] full_d;

    always_comb begin
        if (sub_i) begin
            lo_d   = {1'b0, a_i[NIB_W-1:0]} - {1'b0, b_i[NIB_W-1:0]}
                     - {{NIB_W{1'b0}}, cin_i};
            full_d = {1'b0, a_i} - {1'b0, b_i} - {{DATA_W{1'b0}}, cin_i};
        end else begin
            lo_d   = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_i[NIB_W-1:0]}
                     + {{NIB_W{1'b0}}, cin_i};
            full_d = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
        end
        res_o   = full_d[DATA_W-1:0];
        half_o  = lo_d[NIB_W];
        carry_o = full_d[DATA_W];
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [1:0]        sel_i,
    output logic [DATA_W-1:0] res_o
);
    always_comb begin
        unique case (sel_i)
            2'b00:   res_o = a_i & b_i;
            2'b01:   res_o = a_i ^ b_i;
            default: res_o = a_i | b_i;
        endcase
    end
endmodule

// File: rtl/alu8_step.sv
module alu8_step #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] val_i,
    input  logic              dec_i,
    output logic [DATA_W-1:0] res_o,
    output logic              half_o
);
    localparam int NIB_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    always_comb begin
        if (dec_i) begin
            res_o  = val_i - ONE;
            half_o = (res_o[NIB_W-1:0] == {NIB_W{1'b1}});
        end else begin
            res_o  = val_i + ONE;
            half_o = (res_o[NIB_W-1:0] == {NIB_W{1'b0}});
        end
    end
endmodule

// File: rtl/accflag_alu.sv
module accflag_alu
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        unary_sel,
    input  logic [2:0]        op_sel,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic [FLAG_W-1:0] flags_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] acc_out,
    output logic [FLAG_W-1:0] flags_out
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] acc;
        logic [FLAG_W-1:0] flg;
    } state_t;

    state_t st_d, st_q;

    alu_op_e op_w;
    unary_e  un_w;
    logic    carry_in_w;
    logic    as_sub_w, as_cin_w, as_half_w, as_carry_w;
    logic    st_half_w;
    logic [DATA_W-1:0] as_res_w, lg_res_w, st_res_w;
    flag_t   f_w;

    assign op_w       = alu_op_e'(op_sel);
    assign un_w       = unary_e'(unary_sel);
    assign carry_in_w = flags_in[FC_BIT];
    assign as_sub_w   = (op_w == OP_SUB) || (op_w == OP_SBC) || (op_w == OP_CMP);
    assign as_cin_w   = ((op_w == OP_ADC) || (op_w == OP_SBC)) && carry_in_w;

    alu8_addsub #(.DATA_W(DATA_W)) addsub_i (
        .a_i    (acc_in),
        .b_i    (opnd_in),
        .cin_i  (as_cin_w),
        .sub_i  (as_sub_w),
        .res_o  (as_res_w),
        .half_o (as_half_w),
        .carry_o(as_carry_w)
    );

    alu8_logic #(.DATA_W(DATA_W)) logic_i (
        .a_i  (acc_in),
        .b_i  (opnd_in),
        .sel_i(op_sel[1:0]),
        .res_o(lg_res_w)
    );

    alu8_step #(.DATA_W(DATA_W)) step_i (
        .val_i (opnd_in),
        .dec_i (un_w == UN_DEC),
        .res_o (st_res_w),
        .half_o(st_half_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        f_w      = '0;
        if (in_valid) begin
            unique case (un_w)
                UN_BIN: begin
                    if (op_w inside {OP_AND, OP_XOR, OP_OR}) begin
                        st_d.acc = lg_res_w;
                        f_w.z    = (lg_res_w == '0);
                        f_w.h    = (op_w == OP_AND);
                    end else begin
                        st_d.acc = (op_w == OP_CMP) ? acc_in : as_res_w;
                        f_w.z    = (as_res_w == '0);
                        f_w.n    = as_sub_w;
                        f_w.h    = as_half_w;
                        f_w.c    = as_carry_w;
                    end
                    st_d.flg = pack_flags(f_w);
                end
                UN_INC, UN_DEC: begin
                    st_d.acc = st_res_w;
                    f_w.z    = (st_res_w == '0);
                    f_w.n    = (un_w == UN_DEC);
                    f_w.h    = st_half_w;
                    f_w.c    = carry_in_w;
                    st_d.flg = pack_flags(f_w);
                end
                default: begin
                    st_d.acc = acc_in;
                    st_d.flg = flags_in & FLAG_MASK;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign acc_out   = st_q.acc;
    assign flags_out = st_q.flg;

    // R12
    valid_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R12
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(acc_out) && $stable(flags_out)));

    // R5
    cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && unary_sel == 2'b00 && op_sel == 3'b111)
        |=> (acc_out == $past(acc_in) && flags_out[FN_BIT]));

    // R6
    logic_clears_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && unary_sel == 2'b00 && op_sel[2] && op_sel != 3'b111)
        |=> (!flags_out[FC_BIT] && !flags_out[FN_BIT]));

    // R8
    step_keeps_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (unary_sel == 2'b01 || unary_sel == 2'b10))
        |=> (flags_out[FC_BIT] == $past(flags_in[FC_BIT])));

    // R10
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && unary_sel == 2'b11)
        |=> (acc_out == $past(acc_in) && flags_out[7:4] == $past(flags_in[7:4])));

    // R11
    low_flags_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flags_out[3:0] == 4'b0000));
endmodule

// File: tb/accflag_alu_tb.sv
module accflag_alu_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 28;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] unary_sel = 2'b00;
    logic [2:0] op_sel = 3'b000;
    logic [7:0] acc_in = 8'h00, opnd_in = 8'h00, flags_in = 8'h00;
    logic       out_valid;
    logic [7:0] acc_out, flags_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    accflag_alu dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .unary_sel(unary_sel), .op_sel(op_sel),
        .acc_in(acc_in), .opnd_in(opnd_in), .flags_in(flags_in),
        .out_valid(out_valid), .acc_out(acc_out), .flags_out(flags_out)
    );

    // {tag[3:0], unary[1:0], op[2:0], acc, opnd, flags_in, exp_acc, exp_flags}
    // flags: Z=80 N=40 H=20 C=10
    localparam logic [48:0] VEC [NVEC] = '{
        {4'd7,  2'b00, 3'd0, 8'h3A, 8'hC6, 8'h00, 8'h00, 8'hB0}, // R7 R3 add wraps
        {4'd11, 2'b00, 3'd0, 8'h12, 8'h34, 8'hFF, 8'h46, 8'h00}, // R11 R2 add plain
        {4'd3,  2'b00, 3'd0, 8'h0F, 8'h01, 8'h00, 8'h10, 8'h20}, // R3 nibble carry
        {4'd2,  2'b00, 3'd1, 8'h0E, 8'h01, 8'h10, 8'h10, 8'h20}, // R2 adc cin=1
        {4'd3,  2'b00, 3'd1, 8'hFF, 8'h00, 8'h10, 8'h00, 8'hB0}, // R3 adc wraps
        {4'd2,  2'b00, 3'd1, 8'h0E, 8'h01, 8'h00, 8'h0F, 8'h00}, // R2 adc cin=0
        {4'd7,  2'b00, 3'd2, 8'h3E, 8'h3E, 8'h10, 8'h00, 8'hC0}, // R7 sub zero
        {4'd4,  2'b00, 3'd2, 8'h10, 8'h01, 8'h00, 8'h0F, 8'h60}, // R4 nibble borrow
        {4'd4,  2'b00, 3'd2, 8'h05, 8'h10, 8'h00, 8'hF5, 8'h50}, // R4 full borrow
        {4'd4,  2'b00, 3'd3, 8'h10, 8'h0F, 8'h10, 8'h00, 8'hE0}, // R4 sbc equal
        {4'd4,  2'b00, 3'd3, 8'h10, 8'h10, 8'h10, 8'hFF, 8'h70}, // R4 sbc borrow
        {4'd2,  2'b00, 3'd3, 8'h20, 8'h01, 8'h00, 8'h1F, 8'h60}, // R2 sbc cin=0
        {4'd6,  2'b00, 3'd4, 8'hF0, 8'h0F, 8'h50, 8'h00, 8'hA0}, // R6 and zero
        {4'd6,  2'b00, 3'd4, 8'h3C, 8'h0F, 8'hF0, 8'h0C, 8'h20}, // R6 and
        {4'd6,  2'b00, 3'd5, 8'h55, 8'h55, 8'h70, 8'h00, 8'h80}, // R6 xor zero
        {4'd6,  2'b00, 3'd5, 8'hA5, 8'h0F, 8'hF0, 8'hAA, 8'h00}, // R6 xor
        {4'd6,  2'b00, 3'd6, 8'h00, 8'h00, 8'hF0, 8'h00, 8'h80}, // R6 or zero
        {4'd6,  2'b00, 3'd6, 8'h80, 8'h01, 8'h70, 8'h81, 8'h00}, // R6 or
        {4'd5,  2'b00, 3'd7, 8'h42, 8'h42, 8'h00, 8'h42, 8'hC0}, // R5 cmp equal
        {4'd5,  2'b00, 3'd7, 8'h42, 8'h50, 8'h00, 8'h42, 8'h50}, // R5 cmp less
        {4'd5,  2'b00, 3'd7, 8'h40, 8'h0F, 8'h10, 8'h40, 8'h60}, // R5 cmp nibble
        {4'd8,  2'b01, 3'd3, 8'h77, 8'hFF, 8'h10, 8'h00, 8'hB0}, // R8 inc wraps
        {4'd8,  2'b01, 3'd0, 8'h00, 8'h0F, 8'h00, 8'h10, 8'h20}, // R8 inc nibble
        {4'd8,  2'b01, 3'd7, 8'h00, 8'h41, 8'h10, 8'h42, 8'h10}, // R8 inc keeps C
        {4'd9,  2'b10, 3'd0, 8'h55, 8'h01, 8'h00, 8'h00, 8'hC0}, // R9 dec zero
        {4'd9,  2'b10, 3'd2, 8'h00, 8'h00, 8'h10, 8'hFF, 8'h70}, // R9 dec wraps
        {4'd9,  2'b10, 3'd5, 8'h00, 8'h20, 8'h00, 8'h1F, 8'h60}, // R9 dec nibble
        {4'd10, 2'b11, 3'd1, 8'h9C, 8'h33, 8'hB7, 8'h9C, 8'hB0}  // R10 pass
    };

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        logic [7:0] keep_acc, keep_flg;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "valid", {7'd0, out_valid}, 8'h00);
        chk("R1", "acc", acc_out, 8'h00);
        chk("R1", "flags", flags_out, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            string rq;
            rq        = $sformatf("R%0d", VEC[i][48:45]);
            unary_sel = VEC[i][44:43];
            op_sel    = VEC[i][42:40];
            acc_in    = VEC[i][39:32];
            opnd_in   = VEC[i][31:24];
            flags_in  = VEC[i][23:16];
            in_valid  = 1'b1;
            @(negedge clk);
            chk("R12", "valid echo", {7'd0, out_valid}, 8'h01);
            chk(rq, $sformatf("acc vec%0d", i), acc_out, VEC[i][15:8]);
            chk(rq, $sformatf("flags vec%0d", i), flags_out, VEC[i][7:0]);
        end

        // R12 strobe low: outputs hold while inputs change
        keep_acc  = acc_out;
        keep_flg  = flags_out;
        in_valid  = 1'b0;
        unary_sel = 2'b00;
        op_sel    = 3'd0;
        acc_in    = 8'h01;
        opnd_in   = 8'h01;
        flags_in  = 8'h00;
        @(negedge clk);
        chk("R12", "valid drops", {7'd0, out_valid}, 8'h00);
        @(negedge clk);
        chk("R12", "acc held", acc_out, keep_acc);
        chk("R12", "flags held", flags_out, keep_flg);

        // R11 pass mode with all-ones flags still clears the low nibble
        in_valid  = 1'b1;
        unary_sel = 2'b11;
        acc_in    = 8'h00;
        flags_in  = 8'hFF;
        @(negedge clk);
        chk("R11", "low nibble", flags_out, 8'hF0);
        chk("R7", "pass zero acc", acc_out, 8'h00);

        // R1 mid-run reset clears everything
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "valid after reset", {7'd0, out_valid}, 8'h00);
        chk("R1", "acc after reset", acc_out, 8'h00);
        chk("R1", "flags after reset", flags_out, 8'h00);
        in_valid = 1'b0;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule